// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This block decides how much of a small microcontroller subsystem stays awake. Software selects a target low-power mode: active, flexi or hibernate. It does this through a mode register on a simple write bus. The mode register will only accept a write that comes straight after a two-word unlock sequence on a separate key register. When the processor then issues its sleep request (WFI), the controller does one of three things. In flexi it gates only the core clock. In hibernate it gates the core clock and powers down the digital peripherals. In active or the reserved mode it leaves everything running. A wake event from the interrupt controller always brings the block back to running and clears the mode field to active.

While in hibernate, the controller also drives three signals. It selects how many SRAM banks are retained, as a one-hot bank vector. It enables the external battery monitor unless the mode register disables it. It turns a supply-low comparator input into a chip reset request. A control register carries a buck-converter enable bit, and that register needs no key.

Two state machines make up the block. The unlock machine has three states: `K_IDLE`, `K_HALF` (first key word seen) and `K_OPEN` (mode write allowed). The power machine also has three states: `PS_RUN`, `PS_DOZE` (flexi sleep) and `PS_HIBER`. The power transitions are:
- doze entry: `PS_RUN` to `PS_DOZE`, on WFI with mode 1.
- hibernate entry: `PS_RUN` to `PS_HIBER`, on WFI with mode 2.
- wake: `PS_DOZE` or `PS_HIBER` to `PS_RUN`, on a wake event.

The unlock transitions are:
- half key: `K_IDLE` to `K_HALF`, on the first key word.
- open: `K_HALF` to `K_OPEN`, on the second key word.
- drop: any state to `K_IDLE`, on a wrong key word or on a mode register write.
- restart: `K_OPEN` to `K_HALF`, on the first key word.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the outputs and registers are as follows. Core clock enabled, peripherals powered, buck enable 0, reset request 0, mode register reading 0x0000, and the unlock machine in `K_IDLE`.
- R2: Addresses: 0 is the key register, 1 is the mode register, 2 is the control register. A write to the mode register is stored only if the two key writes before it were 0x4859 and then 0xF27B. Otherwise the mode register write is ignored.
- R3: A key write that is not the word the unlock machine expects returns it to `K_IDLE`. A mode register write always returns it to `K_IDLE`, so one unlock admits exactly one mode write.
- R4: With mode field (bits [1:0]) equal to 1, a WFI request turns the core clock off and leaves the peripherals powered.
- R5: With mode field equal to 2, a WFI request turns the core clock off and asserts peripheral power-down.
- R6: With mode field equal to 0 or 3, a WFI request leaves the core clock on.
- R7: A wake event in either sleep state returns to `PS_RUN` at the next edge and clears the mode field to 0. Other mode register bits keep their values. A wake event in `PS_RUN` has no effect.
- R8: Mode register bits [5:4] select retained SRAM: 0 = 8 kB, 1 = 16 kB, 2 = 24 kB, 3 = 32 kB. The value is output as a one-hot vector with bit n set for selection n.
- R9: A supply-low input sampled high in `PS_HIBER` raises the chip reset request one cycle later. Supply-low outside hibernate raises no request.
- R10: The battery monitor enable is high only in `PS_HIBER`, and only while mode register bit 3 is 0.
- R11: Control register bit 0 drives the buck enable output. The control register is writable without a key and reads back at address 2.
- R12: Control register writes leave the unlock state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (write and read) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| wfi_req | input | 1 | Processor sleep request |
| wake_irq | input | 1 | Wake event from interrupt controller |
| vreg_low | input | 1 | Regulated supply below retention limit |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_off | output | 1 | Digital peripheral power-down |
| sram_ret_onehot | output | 1<<RET_W | One-hot retained SRAM selection |
| batt_mon_en | output | 1 | External battery monitor enable |
| buck_en | output | 1 | Buck converter enable |
| chip_rst_req | output | 1 | Chip reset request |

## Verification
The bench builds the block with its default parameters: 16-bit data, 2-bit address and a 2-bit retention field. With these values, all four retention codes and their one-hot bank outputs can be reached, as can the reserved mode code 3. The key words are also at their defaults, so both correct and wrong unlock sequences can be exercised word by word, including a repeated first key word.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_FLEXI  = 2'd1,
        PM_HIBER  = 2'd2,
        PM_RSVD   = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DOZE  = 2'd1,
        PS_HIBER = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_HALF = 2'd1,
        K_OPEN = 2'd2
    } key_state_e;

    localparam int ADDR_KEY   = 0;
    localparam int ADDR_MODE  = 1;
    localparam int ADDR_CTRL  = 2;
    localparam int MONOFF_BIT = 3;
    localparam int RET_LSB    = 4;
endpackage

// File: rtl/pmc_key_unlock.sv
module pmc_key_unlock
    import pmc_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY_A = 16'h4859,
    parameter logic [DATA_W-1:0] KEY_B = 16'hF27B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              mode_we,
    output logic              unlock_ok
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= K_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            K_IDLE: begin
                if (key_we) state_d = (key_wdata == KEY_A) ? K_HALF : K_IDLE;
            end
            K_HALF: begin
                if (key_we)       state_d = (key_wdata == KEY_B) ? K_OPEN : K_IDLE;
                else if (mode_we) state_d = K_IDLE;
            end
            K_OPEN: begin
                if (key_we)       state_d = (key_wdata == KEY_A) ? K_HALF : K_IDLE;
                else if (mode_we) state_d = K_IDLE;
            end
            default: state_d = K_IDLE;
        endcase
    end

    always_comb begin
        unlock_ok = (state_q == K_OPEN);
    end

    // R2: opening needs the second key word on the previous edge
    a_r2_open_needs_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_ok) |-> $past(key_we && key_wdata == KEY_B));

    // R3: an open unlock is consumed by one mode write
    a_r3_open_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_ok && mode_we && !key_we) |=> !unlock_ok);
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2,
    parameter int RET_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              unlock_ok,
    input  logic              wake_clr,
    output logic [1:0]        mode_f,
    output logic              mon_off,
    output logic [RET_W-1:0]  ret_sel,
    output logic              buck_q,
    output logic [DATA_W-1:0] bus_rdata
);
    logic mode_wr, ctrl_wr;
    logic unused_wdata_bits;

    assign mode_wr = bus_we && (bus_addr == ADDR_W'(ADDR_MODE)) && unlock_ok;
    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign unused_wdata_bits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_f  <= 2'd0;
            mon_off <= 1'b0;
            ret_sel <= '0;
        end else if (mode_wr) begin
            mode_f  <= wake_clr ? 2'd0 : bus_wdata[1:0];
            mon_off <= bus_wdata[MONOFF_BIT];
            ret_sel <= bus_wdata[RET_LSB +: RET_W];
        end else if (wake_clr) begin
            mode_f  <= 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       buck_q <= 1'b0;
        else if (ctrl_wr) buck_q <= bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_MODE)) begin
            bus_rdata[1:0]                = mode_f;
            bus_rdata[MONOFF_BIT]         = mon_off;
            bus_rdata[RET_LSB +: RET_W]   = ret_sel;
        end else if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[0] = buck_q;
        end
    end

    // R2: mode field moves only on an unlocked write or a wake clear
    a_r2_mode_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_f != $past(mode_f)) |->
            ($past(unlock_ok && bus_we && bus_addr == ADDR_W'(ADDR_MODE)) || $past(wake_clr)));

    // R7: a wake clear leaves the mode field at active
    a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr |=> (mode_f == 2'd0));
endmodule

// File: rtl/pmc_power_fsm.sv
module pmc_power_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_f,
    input  logic       wfi_req,
    input  logic       wake_irq,
    input  logic       vreg_low,
    output logic       core_clk_en,
    output logic       periph_off,
    output logic       wake_clr,
    output logic       chip_rst_req
);
    pwr_state_e state_q, state_d;
    logic       rst_req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PS_RUN;
            rst_req_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rst_req_q <= (state_q == PS_HIBER) && vreg_low;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (wfi_req) begin
                    unique case (pm_mode_e'(mode_f))
                        PM_FLEXI: state_d = PS_DOZE;
                        PM_HIBER: state_d = PS_HIBER;
                        PM_ACTIVE, PM_RSVD: state_d = PS_RUN;
                        default:  state_d = PS_RUN;
                    endcase
                end
            end
            PS_DOZE:  if (wake_irq) state_d = PS_RUN;
            PS_HIBER: if (wake_irq) state_d = PS_RUN;
            default:  state_d = PS_RUN;
        endcase
    end

    always_comb begin
        core_clk_en  = 1'b1;
        periph_off   = 1'b0;
        wake_clr     = 1'b0;
        chip_rst_req = rst_req_q;
        unique case (state_q)
            PS_RUN: ;
            PS_DOZE: begin
                core_clk_en = 1'b0;
                wake_clr    = wake_irq;
            end
            PS_HIBER: begin
                core_clk_en = 1'b0;
                periph_off  = 1'b1;
                wake_clr    = wake_irq;
            end
            default: ;
        endcase
    end

    // R7: wake from any sleep state lands in run
    a_r7_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && wake_irq) |=> (state_q == PS_RUN));

    // R9: a reset request follows a supply-low seen in hibernate
    a_r9_rst_from_hiber: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> $past(periph_off && vreg_low));

    // R6: active or reserved mode keeps the core clocked on WFI
    a_r6_no_sleep_active: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfi_req && (mode_f == 2'd0 || mode_f == 2'd3)) |=> core_clk_en);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter int                ADDR_W = 2,
    parameter int                RET_W  = 2,
    parameter logic [DATA_W-1:0] KEY_A  = 16'h4859,
    parameter logic [DATA_W-1:0] KEY_B  = 16'hF27B,
    localparam int               NBANK  = 1 << RET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wfi_req,
    input  logic              wake_irq,
    input  logic              vreg_low,
    output logic              core_clk_en,
    output logic              periph_off,
    output logic [NBANK-1:0]  sram_ret_onehot,
    output logic              batt_mon_en,
    output logic              buck_en,
    output logic              chip_rst_req
);
    logic             key_we, mode_we, unlock_ok, wake_clr, mon_off;
    logic [1:0]       mode_f;
    logic [RET_W-1:0] ret_sel;

    assign key_we  = bus_we && (bus_addr == ADDR_W'(ADDR_KEY));
    assign mode_we = bus_we && (bus_addr == ADDR_W'(ADDR_MODE));

    pmc_key_unlock #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_wdata (bus_wdata),
        .mode_we   (mode_we),
        .unlock_ok (unlock_ok)
    );

    pmc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RET_W(RET_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .unlock_ok (unlock_ok),
        .wake_clr  (wake_clr),
        .mode_f    (mode_f),
        .mon_off   (mon_off),
        .ret_sel   (ret_sel),
        .buck_q    (buck_en),
        .bus_rdata (bus_rdata)
    );

    pmc_power_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_f       (mode_f),
        .wfi_req      (wfi_req),
        .wake_irq     (wake_irq),
        .vreg_low     (vreg_low),
        .core_clk_en  (core_clk_en),
        .periph_off   (periph_off),
        .wake_clr     (wake_clr),
        .chip_rst_req (chip_rst_req)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign sram_ret_onehot[g] = (ret_sel == RET_W'(g));
    end

    assign batt_mon_en = periph_off && !mon_off;

    // R8: exactly one retention bank selection is driven
    a_r8_ret_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sram_ret_onehot) == 1);

    // R5: peripheral power-down never comes with a running core clock
    a_r5_hiber_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        periph_off |-> !core_clk_en);

    // R4: the core clock only stops in response to a sleep request
    a_r4_stop_on_wfi: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(wfi_req));

    // R10: battery monitor only runs in hibernate
    a_r10_mon_in_hiber: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mon_en |-> periph_off);
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    typedef struct packed {
        logic        we;
        logic [1:0]  addr;
        logic [15:0] wd;
        logic        wfi;
        logic        wake;
        logic        vlow;
        logic [1:0]  raddr;
        logic [15:0] erd;
        logic        ecore;
        logic        epoff;
        logic        ebatt;
        logic        erst;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        '{1'b0,2'd1,16'h0000,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0}, // R1
        '{1'b1,2'd1,16'h0001,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0}, // R2 no key
        '{1'b1,2'd0,16'h4859,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd0,16'hF27B,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,16'h0001,1'b0,1'b0,1'b0,2'd1,16'h0001,1'b1,1'b0,1'b0,1'b0}, // R2 accepted
        '{1'b1,2'd1,16'h0002,1'b0,1'b0,1'b0,2'd1,16'h0001,1'b1,1'b0,1'b0,1'b0}, // R3 consumed
        '{1'b0,2'd0,16'h0000,1'b1,1'b0,1'b0,2'd1,16'h0001,1'b0,1'b0,1'b0,1'b0}, // R4 flexi
        '{1'b0,2'd0,16'h0000,1'b0,1'b1,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0}, // R7 wake
        '{1'b1,2'd0,16'h4859,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd0,16'h1234,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0}, // R3 wrong word
        '{1'b1,2'd0,16'hF27B,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,16'h0002,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0}, // R3 rejected
        '{1'b1,2'd0,16'h4859,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd0,16'hF27B,1'b0,1'b0,1'b0,2'd1,16'h0000,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd2,16'h0001,1'b0,1'b0,1'b0,2'd2,16'h0001,1'b1,1'b0,1'b0,1'b0}, // R11
        '{1'b1,2'd1,16'h0022,1'b0,1'b0,1'b0,2'd1,16'h0022,1'b1,1'b0,1'b0,1'b0}, // R12
        '{1'b0,2'd0,16'h0000,1'b1,1'b0,1'b0,2'd1,16'h0022,1'b0,1'b1,1'b1,1'b0}, // R5 R10
        '{1'b0,2'd0,16'h0000,1'b0,1'b0,1'b1,2'd1,16'h0022,1'b0,1'b1,1'b1,1'b1}, // R9
        '{1'b0,2'd0,16'h0000,1'b0,1'b1,1'b0,2'd1,16'h0020,1'b1,1'b0,1'b0,1'b0}, // R7
        '{1'b0,2'd0,16'h0000,1'b0,1'b0,1'b1,2'd1,16'h0020,1'b1,1'b0,1'b0,1'b0}, // R9 run
        '{1'b1,2'd0,16'h4859,1'b0,1'b0,1'b0,2'd1,16'h0020,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd0,16'hF27B,1'b0,1'b0,1'b0,2'd1,16'h0020,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,16'h000A,1'b0,1'b0,1'b0,2'd1,16'h000A,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd0,16'h0000,1'b1,1'b0,1'b0,2'd1,16'h000A,1'b0,1'b1,1'b0,1'b0}, // R10 off
        '{1'b0,2'd0,16'h0000,1'b0,1'b1,1'b0,2'd1,16'h0008,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd0,16'h0000,1'b1,1'b0,1'b0,2'd1,16'h0008,1'b1,1'b0,1'b0,1'b0}, // R6
        '{1'b0,2'd0,16'h0000,1'b0,1'b1,1'b0,2'd1,16'h0008,1'b1,1'b0,1'b0,1'b0}  // R7 run
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wfi_req = 1'b0, wake_irq = 1'b0, vreg_low = 1'b0;
    logic        core_clk_en, periph_off, batt_mon_en, buck_en, chip_rst_req;
    logic [3:0]  sram_ret_onehot;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wfi_req(wfi_req),
        .wake_irq(wake_irq), .vreg_low(vreg_low), .core_clk_en(core_clk_en),
        .periph_off(periph_off), .sram_ret_onehot(sram_ret_onehot),
        .batt_mon_en(batt_mon_en), .buck_en(buck_en), .chip_rst_req(chip_rst_req)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic op(input logic we, input logic [1:0] addr, input logic [15:0] wd,
                      input logic wfi, input logic wake, input logic vlow, input logic [1:0] raddr);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        wfi_req = wfi; wake_irq = wake; vreg_low = vlow;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = raddr; bus_wdata = 16'h0;
        wfi_req = 1'b0; wake_irq = 1'b0; vreg_low = 1'b0;
        #1;
    endtask

    task automatic unlock();
        op(1'b1, 2'd0, 16'h4859, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b1, 2'd0, 16'hF27B, 1'b0, 1'b0, 1'b0, 2'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd1;
        #1;
        // R1 reset state while reset is held
        chk("R1 core_clk_en", 16'(core_clk_en), 16'h1);
        chk("R1 periph_off", 16'(periph_off), 16'h0);
        chk("R1 buck_en", 16'(buck_en), 16'h0);
        chk("R1 chip_rst_req", 16'(chip_rst_req), 16'h0);
        chk("R1 mode reg", bus_rdata, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VT[i];
            op(v.we, v.addr, v.wd, v.wfi, v.wake, v.vlow, v.raddr);
            chk($sformatf("vec%0d rdata", i), bus_rdata, v.erd);
            chk($sformatf("vec%0d core_clk_en", i), 16'(core_clk_en), 16'(v.ecore));
            chk($sformatf("vec%0d periph_off", i), 16'(periph_off), 16'(v.epoff));
            chk($sformatf("vec%0d batt_mon_en R10", i), 16'(batt_mon_en), 16'(v.ebatt));
            chk($sformatf("vec%0d chip_rst_req R9", i), 16'(chip_rst_req), 16'(v.erst));
        end

        // R11 buck output follows control bit 0
        chk("R11 buck_en", 16'(buck_en), 16'h1);

        // R8 retention one-hot for every selection
        for (int r = 0; r < 4; r++) begin
            unlock();
            op(1'b1, 2'd1, 16'(r << 4), 1'b0, 1'b0, 1'b0, 2'd1);
            chk($sformatf("R8 onehot sel%0d", r), 16'(sram_ret_onehot), 16'(1 << r));
        end

        // R6 reserved mode 3 keeps the core running
        unlock();
        op(1'b1, 2'd1, 16'h0003, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1);
        chk("R6 mode3 core_clk_en", 16'(core_clk_en), 16'h1);

        // R3 repeated first word breaks the sequence
        op(1'b1, 2'd0, 16'h4859, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b1, 2'd0, 16'h4859, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b1, 2'd0, 16'hF27B, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 2'd1);
        chk("R3 double first word", bus_rdata, 16'h0003);

        // R1 reset from flexi sleep
        unlock();
        op(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 2'd1);
        op(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1);
        chk("R4 flexi before reset", 16'(core_clk_en), 16'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 core after reset", 16'(core_clk_en), 16'h1);
        chk("R1 mode after reset", bus_rdata, 16'h0000);
        chk("R1 buck after reset", 16'(buck_en), 16'h0);
        chk("R1 rst_req after reset", 16'(chip_rst_req), 16'h0);
        // R1 key state cleared: a mode write without key is ignored
        op(1'b1, 2'd1, 16'h0002, 1'b0, 1'b0, 1'b0, 2'd1);
        chk("R1 key idle after reset", bus_rdata, 16'h0000);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule